// File: doc/BRIEF.md
# SPI Master with Split Burst and Transmit Counters

This block is a register-programmed SPI master for reading serial flash and similar command-then-data devices. A transaction is described by two byte counts. The total count covers every byte clocked while chip select is low. The transmit count says how many of those bytes come from the transmit queue. Software loads the command and address bytes into a 64-byte transmit FIFO and programs both counts. It then sets the exchange bit. The controller lowers chip select and shifts the queued bytes out MSB first. Once the transmit count is used up, it keeps clocking zero filler bytes until the total is reached.

Every byte shifted in during the transaction lands in a 64-byte receive FIFO, including the ones captured while the command was going out. Software polls the status word for the receive fill level, discards the header bytes, and pops the data. The serial clock is the system clock divided by a parameter (default 4). The bus is SPI mode 0: the clock idles low, MOSI changes after the falling edge, and MISO is sampled on the rising edge. A soft-reset bit empties both FIFOs, aborts any transfer and clears the overflow flag. That bit reads back as 1 until the reset sequence finishes.

Top module: `spi_burst_master`

Register word addresses on `bus_addr`:
- 0 control: bit 0 enable, bit 1 master, bit 2 soft reset.
- 1 exchange: bit 0.
- 2 total byte count.
- 3 transmit byte count.
- 4 status: bits 6:0 receive level, bits 14:8 transmit level, bit 16 transmit overflow.
- 5 transmit data, write only.
- 6 receive data, a read pops it.

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, and the control word, the exchange bit and the status word all read 0.
- R2: Writing 1 to exchange bit 0 (address 1) starts a transfer only when control bits 0 (enable) and 1 (master) are both set. Otherwise exchange reads 0 and chip select stays high.
- R3: During a transfer, chip select is low throughout. SCLK rises exactly 8 times per counted byte, with a period of DIV system clocks, and SCLK is never high while chip select is high.
- R4: The first transmit-count bytes on MOSI are taken in order from the transmit FIFO, MSB first, stable at each SCLK rising edge.
- R5: Bytes after the transmit count, and transmit slots that find the transmit FIFO empty, go out as 0x00.
- R6: Every byte shifted in from MISO (MSB first, sampled on the SCLK rise) is pushed into the receive FIFO in order. The status word bits 6:0 report the receive level.
- R7: The exchange bit clears by itself when the last byte of the total count completes, at the same edge that chip select returns high.
- R8: The transmit FIFO holds 64 bytes, and status bits 14:8 report its level. A transmit-data write while the FIFO is full is dropped and sets status bit 16, which stays set until a soft reset.
- R9: Writing control bit 2 starts a soft reset. That bit reads 1 for SRST_CYCLES cycles and then 0. The reset empties both FIFOs, clears the overflow flag, aborts any transfer, and keeps the enable and master bits as written.
- R10: Reading receive data while the receive FIFO is empty returns 0 and leaves the level unchanged.
- R11: Setting the exchange bit while the total byte count is 0 is ignored: exchange reads 0 and chip select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at address 6) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The properties assume the register bus drives single-cycle strobes that are never X after reset. They also assume DIV is even and at least 4, so each SCLK level lasts two or more system clocks. The bench drives every bus access from the falling clock edge as a one-cycle pulse. It keeps DIV at its default and models the slave so that MISO only changes after a falling SCLK or at chip-select fall. A transfer is always started only after the counts and transmit data are in place, and the counts are never rewritten while the exchange bit is set.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  // register word addresses
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_XFER  = 3'd1,
    RA_BURST = 3'd2,
    RA_TXCNT = 3'd3,
    RA_STAT  = 3'd4,
    RA_TXD   = 3'd5,
    RA_RXD   = 3'd6
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MST_BIT  = 1;
  localparam int CTRL_SRST_BIT = 2;
  localparam int XFER_GO_BIT   = 0;
  localparam int STAT_TXL_LSB  = 8;
  localparam int STAT_OVF_BIT  = 16;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'h00;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;

endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [$clog2(DEPTH):0] level,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q, level_d;
  logic          do_push, do_pop;

  assign full  = (level_q == LW'(DEPTH));
  assign empty = (level_q == '0);
  assign level = level_q;
  assign rdata = mem[rd_ptr_q];

  always_comb begin
    do_push  = push && !full && !clr;
    do_pop   = pop && !empty && !clr;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_ptr_q + AW'(1);
      if (do_pop)  rd_ptr_d = rd_ptr_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level_d = level_q + LW'(1);
        2'b01:   level_d = level_q - LW'(1);
        default: level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  // storage array: no reset, written only through the enable
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

endmodule

// File: rtl/spi_burst_clkdiv.sv
module spi_burst_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine import spi_burst_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  input  logic             tick,
  input  logic             tx_empty,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi
);
  localparam int BC_W = $clog2(BYTE_W) + 1;

  eng_state_e        state_q, state_d;
  logic              sclk_q, sclk_d;
  logic              cs_n_q, cs_n_d;
  logic [BYTE_W-1:0] tx_sh_q, tx_sh_d;
  logic [BYTE_W-1:0] rx_sh_q, rx_sh_d;
  logic [BC_W-1:0]   bit_q, bit_d;
  logic [CNT_W-1:0]  byte_q, byte_d;
  logic [CNT_W-1:0]  sent_q, sent_d;
  logic [CNT_W-1:0]  burst_q, burst_d;
  logic [CNT_W-1:0]  txlen_q, txlen_d;
  logic              take_tx;
  logic [BYTE_W-1:0] next_byte;
  logic              last_byte;

  assign sclk    = sclk_q;
  assign cs_n    = cs_n_q;
  assign mosi    = tx_sh_q[BYTE_W-1];
  assign rx_data = rx_sh_q;
  assign busy    = (state_q == ENG_RUN);

  always_comb begin
    take_tx   = (state_q == ENG_IDLE) ? (tx_len != '0) : (sent_q < txlen_q);
    next_byte = (take_tx && !tx_empty) ? tx_data : FILL_BYTE;
    last_byte = ((byte_q + CNT_W'(1)) == burst_q);

    state_d = state_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    sent_d  = sent_q;
    burst_d = burst_q;
    txlen_d = txlen_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    done    = 1'b0;

    if (abort) begin
      state_d = ENG_IDLE;
      sclk_d  = 1'b0;
      cs_n_d  = 1'b1;
      tx_sh_d = '0;
      bit_d   = '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (start) begin
            state_d = ENG_RUN;
            cs_n_d  = 1'b0;
            sclk_d  = 1'b0;
            burst_d = burst_len;
            txlen_d = tx_len;
            byte_d  = '0;
            bit_d   = '0;
            sent_d  = take_tx ? CNT_W'(1) : '0;
            tx_pop  = take_tx && !tx_empty;
            tx_sh_d = next_byte;
          end
        end
        ENG_RUN: begin
          if (tick) begin
            if (!sclk_q) begin
              // rising edge: capture MISO
              sclk_d  = 1'b1;
              rx_sh_d = {rx_sh_q[BYTE_W-2:0], miso};
              bit_d   = bit_q + BC_W'(1);
            end else begin
              // falling edge: advance MOSI or finish a byte
              sclk_d = 1'b0;
              if (bit_q == BC_W'(BYTE_W)) begin
                rx_push = 1'b1;
                byte_d  = byte_q + CNT_W'(1);
                bit_d   = '0;
                if (last_byte) begin
                  state_d = ENG_IDLE;
                  cs_n_d  = 1'b1;
                  done    = 1'b1;
                  tx_sh_d = '0;
                end else begin
                  tx_pop  = take_tx && !tx_empty;
                  sent_d  = take_tx ? (sent_q + CNT_W'(1)) : sent_q;
                  tx_sh_d = next_byte;
                end
              end else begin
                tx_sh_d = {tx_sh_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
        end
        default: state_d = ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      sent_q  <= '0;
      burst_q <= '0;
      txlen_q <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      sent_q  <= sent_d;
      burst_q <= burst_d;
      txlen_q <= txlen_d;
    end
  end

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master import spi_burst_pkg::*; #(
  parameter int FIFO_DEPTH  = 64,
  parameter int DIV         = 4,
  parameter int SRST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int CNT_W = BYTE_W;
  localparam int LW    = $clog2(FIFO_DEPTH) + 1;
  localparam int SW    = $clog2(SRST_CYCLES + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             en_q, en_d;
  logic             mst_q, mst_d;
  logic             xch_q, xch_d;
  logic             ovf_q, ovf_d;
  logic [CNT_W-1:0] burst_q, burst_d;
  logic [CNT_W-1:0] txcnt_q, txcnt_d;
  logic [SW-1:0]    srst_q, srst_d;
  logic             srst_busy;

  logic             wr_ctrl, wr_xfer, wr_burst, wr_txcnt, wr_txd, rd_rxd;
  logic             start;
  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic [BYTE_W-1:0] tx_head;
  logic [LW-1:0]    tx_level;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_head, rx_byte;
  logic [LW-1:0]    rx_level;
  logic             eng_busy, eng_done, tick;

  assign srst_busy = (srst_q != '0);

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
    wr_xfer  = bus_wr && (bus_addr == RA_XFER);
    wr_burst = bus_wr && (bus_addr == RA_BURST);
    wr_txcnt = bus_wr && (bus_addr == RA_TXCNT);
    wr_txd   = bus_wr && (bus_addr == RA_TXD);
    rd_rxd   = bus_rd && (bus_addr == RA_RXD);
  end

  // register next-state
  always_comb begin
    en_d    = en_q;
    mst_d   = mst_q;
    xch_d   = xch_q;
    ovf_d   = ovf_q;
    burst_d = burst_q;
    txcnt_d = txcnt_q;
    srst_d  = srst_q;
    start   = 1'b0;
    tx_push = 1'b0;

    if (srst_busy) srst_d = srst_q - SW'(1);

    if (wr_ctrl) begin
      en_d  = bus_wdata[CTRL_EN_BIT];
      mst_d = bus_wdata[CTRL_MST_BIT];
      if (bus_wdata[CTRL_SRST_BIT]) srst_d = SW'(SRST_CYCLES);
    end

    if (wr_burst && !xch_q) burst_d = bus_wdata;
    if (wr_txcnt && !xch_q) txcnt_d = bus_wdata;

    if (wr_txd && !srst_busy) begin
      if (tx_full) ovf_d   = 1'b1;
      else         tx_push = 1'b1;
    end

    if (wr_xfer && bus_wdata[XFER_GO_BIT] && en_q && mst_q && !xch_q &&
        (burst_q != '0) && !srst_busy) begin
      start = 1'b1;
      xch_d = 1'b1;
    end

    if (eng_done) xch_d = 1'b0;

    if (srst_busy) begin
      xch_d = 1'b0;
      ovf_d = 1'b0;
      start = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      xch_q   <= 1'b0;
      ovf_q   <= 1'b0;
      burst_q <= '0;
      txcnt_q <= '0;
      srst_q  <= '0;
    end else begin
      en_q    <= en_d;
      mst_q   <= mst_d;
      xch_q   <= xch_d;
      ovf_q   <= ovf_d;
      burst_q <= burst_d;
      txcnt_q <= txcnt_d;
      srst_q  <= srst_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL: begin
        bus_rdata[CTRL_EN_BIT]   = en_q;
        bus_rdata[CTRL_MST_BIT]  = mst_q;
        bus_rdata[CTRL_SRST_BIT] = srst_busy;
      end
      RA_XFER:  bus_rdata[XFER_GO_BIT] = xch_q;
      RA_BURST: bus_rdata[CNT_W-1:0] = burst_q;
      RA_TXCNT: bus_rdata[CNT_W-1:0] = txcnt_q;
      RA_STAT: begin
        bus_rdata[LW-1:0]               = rx_level;
        bus_rdata[STAT_TXL_LSB +: LW]   = tx_level;
        bus_rdata[STAT_OVF_BIT]         = ovf_q;
      end
      RA_RXD:   bus_rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
      default:  bus_rdata = '0;
    endcase
  end

  assign rx_pop = rd_rxd && !rx_empty;

  spi_burst_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (srst_busy),
    .push  (tx_push),
    .wdata (bus_wdata),
    .pop   (tx_pop),
    .rdata (tx_head),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  spi_burst_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (srst_busy),
    .push  (rx_push),
    .wdata (rx_byte),
    .pop   (rx_pop),
    .rdata (rx_head),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  spi_burst_clkdiv #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (eng_busy),
    .tick  (tick)
  );

  spi_burst_engine #(.CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .abort     (srst_busy),
    .start     (start),
    .burst_len (burst_q),
    .tx_len    (txcnt_q),
    .tick      (tick),
    .tx_empty  (tx_empty),
    .tx_data   (tx_head),
    .miso      (spi_miso),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .rx_data   (rx_byte),
    .busy      (eng_busy),
    .done      (eng_done),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi)
  );

  // a full receive queue drops further bytes of a burst
  logic unused_rx_full;
  assign unused_rx_full = rx_full;

endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int DIV        = 4,
  parameter int FIFO_DEPTH = 64,
  parameter int LW         = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sclk,
  input logic          xch,
  input logic          en,
  input logic          mst,
  input logic          ovf,
  input logic          srst_busy,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level
);

  // R3: the serial clock only toggles inside a selected transfer
  a_r3_sclk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R2: a transfer begins only with enable and master set
  a_r2_start_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(en && mst));

  // R7: chip select release coincides with the exchange bit clearing
  a_r7_xch_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !xch);

  // R8: overflow is sticky outside soft reset
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !srst_busy) |=> ovf);

  // R9: soft reset empties both queues and drops the transfer
  a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> (rx_level == '0 && tx_level == '0 && !ovf && cs_n));

  // R6: receive level never exceeds the queue depth
  a_r6_rx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(FIFO_DEPTH));

  // R8: transmit level never exceeds the queue depth
  a_r8_tx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(FIFO_DEPTH));

  // R3: each SCLK high phase spans more than one system clock
  if (DIV / 2 > 1) begin : g_half
    a_r3_sclk_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |=> sclk);
  end

endmodule

bind spi_burst_master spi_burst_master_chk #(
  .DIV(DIV), .FIFO_DEPTH(FIFO_DEPTH), .LW(LW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cs_n      (spi_cs_n),
  .sclk      (spi_sclk),
  .xch       (xch_q),
  .en        (en_q),
  .mst       (mst_q),
  .ovf       (ovf_q),
  .srst_busy (srst_busy),
  .rx_level  (rx_level),
  .tx_level  (tx_level)
);

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
  localparam int DIV = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  spi_burst_master #(.FIFO_DEPTH(64), .DIV(DIV), .SRST_CYCLES(4)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard of expected MOSI bytes
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic expect_mosi(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  // slave model and serial monitor
  logic [7:0] seed;
  bit   mon_on = 0;
  logic prev_cs, prev_sclk;
  int   mon_bits, rises, last_rise, per_err, sclk_err, cs_falls;
  int   sbit, sbyte;
  logic [7:0] mon_sh;

  function automatic logic [7:0] pat(input logic [7:0] s, input int k);
    logic [7:0] t;
    t = 8'(k * 29 + 7);
    return s ^ t;
  endfunction

  task automatic drive_miso();
    logic [7:0] v;
    v = pat(seed, sbyte);
    spi_miso = v[7 - sbit];
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_cs && !spi_cs_n) begin
        cs_falls++;
        mon_bits = 0; rises = 0; last_rise = -1; sbit = 0; sbyte = 0;
        drive_miso();
      end
      if (spi_sclk && spi_cs_n) sclk_err++;
      if (spi_sclk && !prev_sclk) begin
        rises++;
        if (last_rise >= 0 && (cyc - last_rise) != DIV) per_err++;
        last_rise = cyc;
        mon_sh = {mon_sh[6:0], spi_mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          mon_bits = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected MOSI byte", {24'h0, mon_sh}, 32'h0);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(mon_sh == e, t, {24'h0, mon_sh}, {24'h0, e});
          end
        end
      end
      if (!spi_sclk && prev_sclk && !spi_cs_n) begin
        sbit++;
        if (sbit == 8) begin sbit = 0; sbyte++; end
        drive_miso();
      end
      prev_cs   = spi_cs_n;
      prev_sclk = spi_sclk;
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic wait_xfer_clear(input string req);
    logic [31:0] r;
    int n;
    n = 0;
    r = 32'h1;
    while (r[0] && n < 4000) begin
      bus_read(3'd1, r);
      n++;
    end
    check(r[0] == 1'b0, req, r, 32'h0);
  endtask

  // driver: programs counts, starts, then checks serial and receive results
  task automatic do_burst(input int burst, input int txcnt, input logic [7:0] s);
    logic [31:0] r;
    seed = s;
    bus_write(3'd2, 8'(burst));
    bus_write(3'd3, 8'(txcnt));
    bus_write(3'd1, 8'h01);
    wait_xfer_clear("R7 exchange self-clear");
    check(spi_cs_n == 1'b1, "R7 cs_n high after burst", {31'h0, spi_cs_n}, 32'h1);
    check(rises == 8 * burst, "R3 sclk rise count", rises, 8 * burst);
    check(per_err == 0 && sclk_err == 0, "R3 sclk period/idle", per_err + sclk_err, 0);
    check(exp_q.size() == 0, "R4 all expected bytes shifted", exp_q.size(), 0);
    bus_read(3'd4, r);
    check(r[6:0] == 7'(burst), "R6 rx level", r[6:0], burst);
    for (int k = 0; k < burst; k++) begin
      bus_read(3'd6, r);
      check(r[7:0] == pat(s, k), "R6 rx byte", r[7:0], pat(s, k));
    end
  endtask

  initial begin
    logic [31:0] r;
    int f0;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; spi_miso = 0;
    seed = 0; rst_n = 0;
    prev_cs = 1; prev_sclk = 0; mon_bits = 0; rises = 0; last_rise = -1;
    per_err = 0; sclk_err = 0; cs_falls = 0; sbit = 0; sbyte = 0; mon_sh = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    mon_on = 1;

    // R1 reset state
    @(negedge clk);
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_mosi === 1'b0,
          "R1 idle pins", {29'h0, spi_cs_n, spi_sclk, spi_mosi}, 32'h4);
    bus_read(3'd0, r); check(r == 32'h0, "R1 control", r, 0);
    bus_read(3'd1, r); check(r == 32'h0, "R1 exchange", r, 0);
    bus_read(3'd4, r); check(r == 32'h0, "R1 status", r, 0);

    // R2 start ignored without enable/master
    f0 = cs_falls;
    bus_write(3'd2, 8'd2);
    bus_write(3'd0, 8'h01);
    bus_write(3'd1, 8'h01);
    bus_read(3'd1, r); check(r[0] == 1'b0, "R2 exchange ignored", r, 0);
    repeat (20) @(posedge clk);
    check(cs_falls == f0, "R2 cs_n stayed high", cs_falls - f0, 0);

    // R11 zero burst ignored
    bus_write(3'd0, 8'h03);
    bus_write(3'd2, 8'd0);
    bus_write(3'd1, 8'h01);
    bus_read(3'd1, r); check(r[0] == 1'b0, "R11 zero burst exchange", r, 0);
    repeat (20) @(posedge clk);
    check(cs_falls == f0, "R11 cs_n stayed high", cs_falls - f0, 0);

    // R4/R5/R6 command header then filler
    bus_write(3'd5, 8'h03); expect_mosi(8'h03, "R4 tx byte 0");
    bus_write(3'd5, 8'h12); expect_mosi(8'h12, "R4 tx byte 1");
    bus_write(3'd5, 8'h34); expect_mosi(8'h34, "R4 tx byte 2");
    bus_write(3'd5, 8'h56); expect_mosi(8'h56, "R4 tx byte 3");
    for (int k = 0; k < 6; k++) expect_mosi(8'h00, "R5 filler byte");
    do_burst(10, 4, 8'h5A);

    // R10 read of empty receive queue
    bus_read(3'd6, r); check(r == 32'h0, "R10 empty rx read", r, 0);
    bus_read(3'd4, r); check(r[6:0] == 7'd0, "R10 level unchanged", r[6:0], 0);

    // R5 transmit count beyond queued data
    bus_write(3'd5, 8'hA5); expect_mosi(8'hA5, "R4 tx byte");
    expect_mosi(8'h00, "R5 empty-queue filler");
    expect_mosi(8'h00, "R5 empty-queue filler");
    do_burst(3, 3, 8'hC3);

    // R4 all-transmit burst, different slave pattern
    bus_write(3'd5, 8'hFF); expect_mosi(8'hFF, "R4 tx byte");
    bus_write(3'd5, 8'h81); expect_mosi(8'h81, "R4 tx byte");
    do_burst(2, 2, 8'h0F);

    // R8 transmit overflow
    for (int k = 0; k < 64; k++) bus_write(3'd5, 8'(k));
    bus_read(3'd4, r);
    check(r[14:8] == 7'd64 && r[16] == 1'b0, "R8 full, no overflow yet", r, 32'h4000);
    bus_write(3'd5, 8'hEE);
    bus_read(3'd4, r);
    check(r[14:8] == 7'd64 && r[16] == 1'b1, "R8 overflow sticky set", r, 32'h14000);
    repeat (5) @(posedge clk);
    bus_read(3'd4, r);
    check(r[16] == 1'b1, "R8 overflow still set", r, 32'h14000);

    // R9 soft reset
    bus_write(3'd0, 8'h07);
    bus_read(3'd0, r);
    check(r[2:0] == 3'b111, "R9 reset bit reads 1", r, 32'h7);
    repeat (6) @(posedge clk);
    bus_read(3'd0, r);
    check(r == 32'h3, "R9 reset done, mode kept", r, 32'h3);
    bus_read(3'd4, r);
    check(r == 32'h0, "R9 queues and overflow cleared", r, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired R7 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule